// File: doc/BRIEF.md
# In-Order Memory Address Generation Gate

This block sits beside the reservation stations of an out-of-order core. Each cycle it decides which waiting load or store, if any, may form its effective address. A candidate needs its base operand available. It must also have no older memory operation still in flight in the reorder buffer whose address is missing. The result is that addresses are produced strictly in program order among memory operations. Later stages can then rely on every older access already having a known address.

The reorder buffer side arrives as flat vectors: busy bit, memory-op bit, address-done bit and issue sequence number per entry. The reservation-station side supplies per slot: valid, store flag, sequence number, reorder-buffer index, base producer tag, base value, offset and store data.

The grant, the sum and the store write-back fields are registered and appear one cycle after the candidate was presented. The surrounding logic is expected to set the address-done flag of the granted entry and to release the slot on that output. Until that happens, the block treats its own pending grant as already done.

Top module: `agu_order_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, `gnt_valid` and `st_ready_valid` are 0.
- R2: A candidate is granted only if no reorder-buffer entry other than its own is busy, marked memory-op, has address-done clear, and is older than the candidate; a blocked candidate is granted in a later cycle once the blocker is done.
- R3: Entry A is older than candidate B when bit SEQ_W-1 of (seqA - seqB) modulo 2^SEQ_W is 1, so ordering holds across sequence wrap-around.
- R4: A candidate is eligible only when its base tag equals ROB_DEPTH, the "no producer" value.
- R5: One cycle after a grant decision, `gnt_addr` equals base plus offset modulo 2^DATA_W of the granted slot, with `gnt_slot` and `gnt_rob` naming that slot and its reorder-buffer entry.
- R6: A granted store raises `st_ready_valid` with `st_data` equal to its store data (the address is `gnt_addr`); a granted load leaves `st_ready_valid` at 0.
- R7: When several candidates are eligible in one cycle, the oldest by sequence number is granted and the others wait.
- R8: The entry granted in the previous cycle counts as address-done, is not granted again in the next cycle and does not block others in it.
- R9: Older entries that are not busy, or not memory operations, never block a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_busy | input | ROB_DEPTH | Entry in flight |
| rob_mem | input | ROB_DEPTH | Entry holds a load or store |
| rob_addr_done | input | ROB_DEPTH | Entry's address already formed |
| rob_seq | input | ROB_DEPTH*SEQ_W | Issue sequence number per entry |
| cand_valid | input | RS_DEPTH | Slot holds a memory op waiting for its address |
| cand_store | input | RS_DEPTH | Slot op is a store |
| cand_seq | input | RS_DEPTH*SEQ_W | Slot sequence number |
| cand_rob | input | RS_DEPTH*ROB_IDX_W | Slot's reorder-buffer index |
| cand_tag | input | RS_DEPTH*TAG_W | Producer tag of the base operand |
| cand_base | input | RS_DEPTH*DATA_W | Base register value |
| cand_off | input | RS_DEPTH*DATA_W | Address offset |
| cand_data | input | RS_DEPTH*DATA_W | Store data operand |
| gnt_valid | output | 1 | Address produced this cycle |
| gnt_slot | output | RS_IDX_W | Granted reservation-station slot |
| gnt_rob | output | ROB_IDX_W | Reorder-buffer entry to mark address-done |
| gnt_addr | output | DATA_W | Effective address |
| st_ready_valid | output | 1 | Store write-back: mark entry ready |
| st_data | output | DATA_W | Store data for the reorder-buffer entry |

## Verification
The gate is driven with a lone load whose only busy memory entry is its own, which separates self-exclusion from real blocking. An older store with an unavailable base holds back a younger load until it gets its own address. This shows the in-order retry and the store write-back fields. Older non-memory, idle and younger entries are placed around a candidate to show they are ignored. Sequence numbers straddling the wrap point tell true age ordering from plain magnitude. Two mutually independent candidates with reversed slot order show that age, not slot index, picks the winner. Holding a granted slot in place shows that the pending grant is not repeated.

// File: rtl/agu_order_gate.sv
module agu_order_gate #(
  parameter int ROB_DEPTH = 8,
  parameter int RS_DEPTH  = 4,
  parameter int SEQ_W     = 5,
  parameter int DATA_W    = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ROB_DEPTH-1:0]                  rob_busy,
  input  logic [ROB_DEPTH-1:0]                  rob_mem,
  input  logic [ROB_DEPTH-1:0]                  rob_addr_done,
  input  logic [ROB_DEPTH*SEQ_W-1:0]            rob_seq,
  input  logic [RS_DEPTH-1:0]                   cand_valid,
  input  logic [RS_DEPTH-1:0]                   cand_store,
  input  logic [RS_DEPTH*SEQ_W-1:0]             cand_seq,
  input  logic [RS_DEPTH*$clog2(ROB_DEPTH)-1:0] cand_rob,
  input  logic [RS_DEPTH*$clog2(ROB_DEPTH+1)-1:0] cand_tag,
  input  logic [RS_DEPTH*DATA_W-1:0]            cand_base,
  input  logic [RS_DEPTH*DATA_W-1:0]            cand_off,
  input  logic [RS_DEPTH*DATA_W-1:0]            cand_data,
  output logic                                  gnt_valid,
  output logic [(RS_DEPTH>1 ? $clog2(RS_DEPTH) : 1)-1:0] gnt_slot,
  output logic [$clog2(ROB_DEPTH)-1:0]          gnt_rob,
  output logic [DATA_W-1:0]                     gnt_addr,
  output logic                                  st_ready_valid,
  output logic [DATA_W-1:0]                     st_data
);
  localparam int ROB_IDX_W = $clog2(ROB_DEPTH);
  localparam int TAG_W     = $clog2(ROB_DEPTH + 1);
  localparam int RS_IDX_W  = RS_DEPTH > 1 ? $clog2(RS_DEPTH) : 1;
  localparam logic [TAG_W-1:0] NO_PRODUCER = TAG_W'(ROB_DEPTH);

  function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [SEQ_W-1:0]     e_seq  [ROB_DEPTH];
  logic [SEQ_W-1:0]     c_seq  [RS_DEPTH];
  logic [ROB_IDX_W-1:0] c_rob  [RS_DEPTH];
  logic [TAG_W-1:0]     c_tag  [RS_DEPTH];
  logic [DATA_W-1:0]    c_base [RS_DEPTH];
  logic [DATA_W-1:0]    c_off  [RS_DEPTH];
  logic [DATA_W-1:0]    c_data [RS_DEPTH];

  for (genvar j = 0; j < ROB_DEPTH; j++) begin : g_rob
    assign e_seq[j] = rob_seq[j*SEQ_W +: SEQ_W];
  end
  for (genvar i = 0; i < RS_DEPTH; i++) begin : g_rs
    assign c_seq[i]  = cand_seq[i*SEQ_W +: SEQ_W];
    assign c_rob[i]  = cand_rob[i*ROB_IDX_W +: ROB_IDX_W];
    assign c_tag[i]  = cand_tag[i*TAG_W +: TAG_W];
    assign c_base[i] = cand_base[i*DATA_W +: DATA_W];
    assign c_off[i]  = cand_off[i*DATA_W +: DATA_W];
    assign c_data[i] = cand_data[i*DATA_W +: DATA_W];
  end

  logic [ROB_DEPTH-1:0] blocker;
  logic [RS_DEPTH-1:0]  elig;
  logic                 found;
  logic [RS_IDX_W-1:0]  sel;

  always_comb begin
    for (int j = 0; j < ROB_DEPTH; j++)
      blocker[j] = rob_busy[j] && rob_mem[j] && !rob_addr_done[j] &&
                   !(gnt_valid && gnt_rob == ROB_IDX_W'(j));
  end

  always_comb begin
    for (int i = 0; i < RS_DEPTH; i++) begin
      elig[i] = cand_valid[i] && (c_tag[i] == NO_PRODUCER) &&
                !(gnt_valid && gnt_rob == c_rob[i]);
      for (int j = 0; j < ROB_DEPTH; j++)
        if (blocker[j] && c_rob[i] != ROB_IDX_W'(j) && is_older(e_seq[j], c_seq[i]))
          elig[i] = 1'b0;
    end
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < RS_DEPTH; i++)
      if (elig[i] && (!found || is_older(c_seq[i], c_seq[sel]))) begin
        found = 1'b1;
        sel   = RS_IDX_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid      <= 1'b0;
      gnt_slot       <= '0;
      gnt_rob        <= '0;
      gnt_addr       <= '0;
      st_ready_valid <= 1'b0;
      st_data        <= '0;
    end else begin
      gnt_valid      <= found;
      st_ready_valid <= found && cand_store[sel];
      if (found) begin
        gnt_slot <= sel;
        gnt_rob  <= c_rob[sel];
        gnt_addr <= c_base[sel] + c_off[sel];
        st_data  <= c_data[sel];
      end
    end
  end
endmodule

module agu_order_gate_chk #(
  parameter int ROB_DEPTH = 8,
  parameter int RS_DEPTH  = 4,
  parameter int SEQ_W     = 5,
  parameter int DATA_W    = 32
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic [RS_DEPTH-1:0]                     cand_valid,
  input logic [RS_DEPTH*$clog2(ROB_DEPTH)-1:0]   cand_rob,
  input logic [RS_DEPTH*$clog2(ROB_DEPTH+1)-1:0] cand_tag,
  input logic [RS_DEPTH*DATA_W-1:0]              cand_base,
  input logic [RS_DEPTH*DATA_W-1:0]              cand_off,
  input logic                                    gnt_valid,
  input logic [(RS_DEPTH>1 ? $clog2(RS_DEPTH) : 1)-1:0] gnt_slot,
  input logic [$clog2(ROB_DEPTH)-1:0]            gnt_rob,
  input logic [DATA_W-1:0]                       gnt_addr,
  input logic                                    st_ready_valid
);
  localparam int ROB_IDX_W = $clog2(ROB_DEPTH);
  localparam int TAG_W     = $clog2(ROB_DEPTH + 1);

  logic [DATA_W-1:0]    sum_q   [RS_DEPTH];
  logic [ROB_IDX_W-1:0] rob_q   [RS_DEPTH];
  logic [RS_DEPTH-1:0]  tag_ok_q;
  logic [RS_DEPTH-1:0]  valid_q;

  always_ff @(posedge clk) begin
    valid_q <= cand_valid;
    for (int i = 0; i < RS_DEPTH; i++) begin
      sum_q[i]    <= cand_base[i*DATA_W +: DATA_W] + cand_off[i*DATA_W +: DATA_W];
      rob_q[i]    <= cand_rob[i*ROB_IDX_W +: ROB_IDX_W];
      tag_ok_q[i] <= cand_tag[i*TAG_W +: TAG_W] == TAG_W'(ROB_DEPTH);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!gnt_valid && !st_ready_valid));

  assert_granted_slot_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (valid_q[gnt_slot] && rob_q[gnt_slot] == gnt_rob));

  assert_base_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> tag_ok_q[gnt_slot]);

  assert_addr_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_addr == sum_q[gnt_slot]);

  assert_store_has_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready_valid |-> gnt_valid);

  assert_no_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !(gnt_valid && gnt_rob == $past(gnt_rob)));
endmodule

bind agu_order_gate agu_order_gate_chk #(
  .ROB_DEPTH(ROB_DEPTH), .RS_DEPTH(RS_DEPTH), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_rob(cand_rob),
  .cand_tag(cand_tag), .cand_base(cand_base), .cand_off(cand_off),
  .gnt_valid(gnt_valid), .gnt_slot(gnt_slot), .gnt_rob(gnt_rob),
  .gnt_addr(gnt_addr), .st_ready_valid(st_ready_valid)
);

// File: tb/agu_order_gate_tb.sv
module agu_order_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROBD = 8;
  localparam int RSD  = 4;
  localparam int SW   = 5;
  localparam int DW   = 32;
  localparam int RIW  = 3;
  localparam int TW   = 4;

  logic clk = 0, rst_n = 0;
  logic [ROBD-1:0] rob_busy = '0, rob_mem = '0, rob_addr_done = '0;
  logic [ROBD*SW-1:0] rob_seq = '0;
  logic [RSD-1:0] cand_valid = '0, cand_store = '0;
  logic [RSD*SW-1:0] cand_seq = '0;
  logic [RSD*RIW-1:0] cand_rob = '0;
  logic [RSD*TW-1:0] cand_tag = '0;
  logic [RSD*DW-1:0] cand_base = '0, cand_off = '0, cand_data = '0;
  logic gnt_valid, st_ready_valid;
  logic [1:0] gnt_slot;
  logic [RIW-1:0] gnt_rob;
  logic [DW-1:0] gnt_addr, st_data;

  agu_order_gate #(.ROB_DEPTH(ROBD), .RS_DEPTH(RSD), .SEQ_W(SW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rob_busy(rob_busy), .rob_mem(rob_mem),
    .rob_addr_done(rob_addr_done), .rob_seq(rob_seq), .cand_valid(cand_valid),
    .cand_store(cand_store), .cand_seq(cand_seq), .cand_rob(cand_rob),
    .cand_tag(cand_tag), .cand_base(cand_base), .cand_off(cand_off),
    .cand_data(cand_data), .gnt_valid(gnt_valid), .gnt_slot(gnt_slot),
    .gnt_rob(gnt_rob), .gnt_addr(gnt_addr), .st_ready_valid(st_ready_valid),
    .st_data(st_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit env_on = 1;
  int exp_v = 0, exp_slot = 0, exp_rob = 0, exp_st = 0;
  logic [DW-1:0] exp_addr = '0, exp_data = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic bit older(input int a, input int b);
    return ((((a - b) % 32) + 32) % 32) >= 16;
  endfunction

  task automatic set_rob(input int e, input bit b, input bit m, input bit d, input int s);
    rob_busy[e] = b; rob_mem[e] = m; rob_addr_done[e] = d; rob_seq[e*SW +: SW] = SW'(s);
  endtask

  task automatic set_cand(input int k, input bit st, input int s, input int r, input int t,
                          input logic [DW-1:0] b, input logic [DW-1:0] o, input logic [DW-1:0] d);
    cand_valid[k] = 1; cand_store[k] = st; cand_seq[k*SW +: SW] = SW'(s);
    cand_rob[k*RIW +: RIW] = RIW'(r); cand_tag[k*TW +: TW] = TW'(t);
    cand_base[k*DW +: DW] = b; cand_off[k*DW +: DW] = o; cand_data[k*DW +: DW] = d;
  endtask

  task automatic tick();
    int nv, ns, best_seq;
    nv = 0; ns = 0; best_seq = 0;
    if (rst_n) begin
      for (int i = 0; i < RSD; i++) begin
        bit ok;
        int ri, si;
        ri = int'(cand_rob[i*RIW +: RIW]); si = int'(cand_seq[i*SW +: SW]);
        ok = cand_valid[i] && int'(cand_tag[i*TW +: TW]) == ROBD && !(exp_v != 0 && exp_rob == ri);
        for (int j = 0; j < ROBD; j++)
          if (j != ri && rob_busy[j] && rob_mem[j] && !rob_addr_done[j] &&
              !(exp_v != 0 && exp_rob == j) && older(int'(rob_seq[j*SW +: SW]), si))
            ok = 0;
        if (ok && (nv == 0 || older(si, best_seq))) begin nv = 1; ns = i; best_seq = si; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    exp_v = nv;
    if (nv != 0) begin
      exp_slot = ns;
      exp_rob  = int'(cand_rob[ns*RIW +: RIW]);
      exp_addr = cand_base[ns*DW +: DW] + cand_off[ns*DW +: DW];
      exp_data = cand_data[ns*DW +: DW];
      exp_st   = int'(cand_store[ns]);
    end else exp_st = 0;
    chk(gnt_valid == exp_v[0], cur_req, gnt_valid, exp_v);
    chk(st_ready_valid == exp_st[0], cur_req, st_ready_valid, exp_st);
    if (exp_v != 0) begin
      chk(int'(gnt_slot) == exp_slot && int'(gnt_rob) == exp_rob, cur_req, gnt_slot, exp_slot);
      chk(gnt_addr == exp_addr, cur_req, gnt_addr, exp_addr);
      if (exp_st != 0) chk(st_data == exp_data, cur_req, st_data, exp_data);
      if (env_on) begin rob_addr_done[exp_rob] = 1; cand_valid[exp_slot] = 0; end
    end
  endtask

  task automatic clear_all();
    rob_busy = '0; rob_mem = '0; rob_addr_done = '0; cand_valid = '0; cand_store = '0;
    env_on = 1;
    tick(); tick();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    tick(); tick();
    chk(!gnt_valid && !st_ready_valid, "R1 during reset", gnt_valid, 0);
    rst_n = 1;
    tick();
    chk(!gnt_valid && !st_ready_valid, "R1 after reset", gnt_valid, 0);

    // R5, R6 load, own entry excluded (R2)
    cur_req = "R5";
    set_rob(0, 1, 1, 0, 3);
    set_cand(0, 0, 3, 0, ROBD, 32'h1000, 32'h24, 32'h55);
    tick();
    chk(gnt_valid && gnt_addr == 32'h1024, "R5 load address", gnt_addr, 32'h1024);
    chk(!st_ready_valid, "R6 load no store mark", st_ready_valid, 0);
    clear_all();

    // R8 pending grant not repeated
    cur_req = "R8";
    env_on = 0;
    set_rob(1, 1, 1, 0, 7);
    set_cand(1, 0, 7, 1, ROBD, 32'h40, 32'h4, 0);
    tick();
    chk(gnt_valid == 1, "R8 first grant", gnt_valid, 1);
    tick();
    chk(gnt_valid == 0, "R8 no repeat next cycle", gnt_valid, 0);
    clear_all();

    // R2 blocking and retry, R6 store write-back
    cur_req = "R2";
    set_rob(1, 1, 1, 0, 4);
    set_rob(2, 1, 1, 0, 5);
    set_cand(1, 1, 4, 1, 2, 32'h100, 32'h4, 32'hCAFE);
    set_cand(2, 0, 5, 2, ROBD, 32'h200, 32'h8, 0);
    tick(); tick(); tick();
    chk(gnt_valid == 0, "R2 younger load held", gnt_valid, 0);
    cand_tag[1*TW +: TW] = TW'(ROBD);
    cur_req = "R6";
    tick();
    chk(gnt_valid && gnt_slot == 1 && st_ready_valid && st_data == 32'hCAFE && gnt_addr == 32'h104,
        "R6 store write-back", st_data, 32'hCAFE);
    cur_req = "R2";
    tick();
    chk(gnt_valid && gnt_slot == 2 && gnt_addr == 32'h208, "R2 retry after blocker", gnt_addr, 32'h208);
    clear_all();

    // R9 non-blocking entries
    cur_req = "R9";
    set_rob(3, 1, 0, 0, 1);
    set_rob(4, 0, 1, 0, 2);
    set_rob(5, 1, 1, 0, 9);
    set_rob(6, 1, 1, 0, 6);
    set_cand(0, 0, 6, 6, ROBD, 32'h10, 32'h10, 0);
    tick();
    chk(gnt_valid && gnt_rob == 6, "R9 ignored entries", gnt_rob, 6);
    clear_all();

    // R4 base not available
    cur_req = "R4";
    set_rob(0, 1, 1, 0, 2);
    set_cand(0, 0, 2, 0, 3, 32'h10, 32'h1, 0);
    tick(); tick();
    chk(gnt_valid == 0, "R4 tag pending", gnt_valid, 0);
    cand_tag[0 +: TW] = TW'(ROBD);
    tick();
    chk(gnt_valid == 1, "R4 tag now free", gnt_valid, 1);
    clear_all();

    // R3 wrap-around
    cur_req = "R3";
    set_rob(0, 1, 1, 0, 30);
    set_rob(1, 1, 1, 0, 1);
    set_cand(0, 0, 1, 1, ROBD, 32'h20, 32'h2, 0);
    tick(); tick();
    chk(gnt_valid == 0, "R3 wrapped older blocks", gnt_valid, 0);
    rob_addr_done[0] = 1;
    tick();
    chk(gnt_valid == 1, "R3 unblocked", gnt_valid, 1);
    clear_all();
    set_rob(0, 1, 1, 0, 3);
    set_rob(1, 1, 1, 0, 30);
    set_cand(0, 0, 30, 1, ROBD, 32'h30, 32'h3, 0);
    tick();
    chk(gnt_valid == 1, "R3 wrapped younger ignored", gnt_valid, 1);
    clear_all();

    // R7 oldest wins
    cur_req = "R7";
    set_cand(0, 0, 12, 2, ROBD, 32'hA00, 32'h1, 0);
    set_cand(3, 0, 10, 3, ROBD, 32'hB00, 32'h2, 0);
    tick();
    chk(gnt_valid && gnt_slot == 3, "R7 oldest first", gnt_slot, 3);
    tick();
    chk(gnt_valid && gnt_slot == 0, "R7 next one", gnt_slot, 0);
    clear_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule